// File: doc/BRIEF.md
# Spread Spectrum Divider Modulator

This block produces the feedback divide word for a fractional-N PLL and makes it move over time, so that the PLL output frequency is spread over a band and its spectral peak is lowered. The divide word is an unsigned fixed-point number with a 12-bit integer part and a 24-bit fraction, where the fraction counts units of 2^-24. A 5-bit depth code picks the spread in steps of one tenth of a percent. A placement select picks either a window centred on the nominal value or a window that lies wholly below it. A shape select picks either a linear up/down sweep or a pseudo-random walk inside that window.

The nominal word, the depth code, the placement and the shape are captured on the clock edge where the enable is first seen high. Changes to these inputs while the block is enabled have no effect. The modulation-rate input is read live and sets how many clocks lie between output updates. Each update is marked by a one-cycle valid strobe. While the enable is low the output simply follows the nominal input.

Top module: `ssc_divmod`

## Requirements
- R1: While reset is held, and whenever the registered enable is low, the output word {div_int, div_frac} equals the nominal input {nom_int, nom_frac}. During reset div_valid is 0.
- R2: The deviation is dev = floor(N × S / 1000), where N is the 36-bit nominal word and S the depth code. In centre placement (down_mode = 0) the window is [N − dev, N + dev]. Example: N = 50.0 and S = 15 give bounds 49.25 (0x031_400000) and 50.75 (0x032_C00000).
- R3: In down placement (down_mode = 1) the window is [N − dev, N], so the output never exceeds the nominal value.
- R4: A depth code of 0 keeps the output at the captured nominal value for as long as the block is enabled, in both shapes.
- R5: Triangle shape (shape_prng = 0): on the edge that captures the settings, the output loads the lower bound. Each update moves it by step = max(1, (hi − lo) >> STEP_SHIFT), first upward. When the next step would reach or pass a bound, the output lands exactly on that bound and the direction reverses.
- R6: Pseudo-random shape (shape_prng = 1): each update sets the output to lo + floor((hi − lo) × L / 2^LFSR_W). L is the next state of a maximal-length LFSR seeded to 1 at reset. The output therefore stays in [lo, hi) when hi > lo, and it varies from update to update.
- R7: An update occurs every rate + 1 clocks, counted from the capture edge. div_valid is high for exactly the cycle after each update edge. While enabled, the output changes only in cycles where div_valid is high.
- R8: Changes to nom_int, nom_frac, spread, down_mode and shape_prng while enabled do not alter the output sequence.
- R9: One clock after the enable is sampled low, the output returns to the nominal input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Modulation enable; rising edge captures settings |
| nom_int | input | INT_W | Nominal divider, integer part |
| nom_frac | input | FRAC_W | Nominal divider, fraction in 2^-FRAC_W units |
| spread | input | SPREAD_W | Depth code, 0.1 % per step, 0 = none |
| down_mode | input | 1 | 0 = centre placement, 1 = down placement |
| shape_prng | input | 1 | 0 = triangle sweep, 1 = pseudo-random |
| rate | input | RATE_W | Clocks between updates minus one |
| div_int | output | INT_W | Modulated divider, integer part |
| div_frac | output | FRAC_W | Modulated divider, fraction |
| div_valid | output | 1 | One-cycle strobe per update |

## Verification
The bench builds the block with the default 12.24 word and 5-bit depth code. It uses STEP_SHIFT = 3, so a half sweep takes about nine updates, and an 8-bit rate input driven in the range 0 to 3. Together these let every triangle run reach and reverse at both bounds within a few dozen updates. LFSR_W = 8 keeps the pseudo-random scaling product small. The full 36-bit range stays in use, so the depth code 31 at a near-full nominal value and a nominal of exactly 1.0 are both covered.

// File: rtl/ssc_pkg.sv
// Shared encodings and constants for the spread spectrum divider modulator.
// Assumes LFSR widths are chosen from the set the tap function supports.
package ssc_pkg;

    typedef enum logic {
        SHAPE_TRI  = 1'b0,
        SHAPE_PRNG = 1'b1
    } shape_e;

    typedef enum logic {
        PLACE_CENTER = 1'b0,
        PLACE_DOWN   = 1'b1
    } place_e;

    // One depth step is one part in this many of the nominal value.
    localparam int PERMILLE = 1000;

    // Feedback tap mask for a left-shifting Fibonacci LFSR of width w.
    function automatic logic [31:0] lfsr_taps(input int w);
        case (w)
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            10:      return 32'h0000_0240;
            12:      return 32'h0000_0829;
            16:      return 32'h0000_D008;
            20:      return 32'h0009_0000;
            24:      return 32'h00E1_0000;
            default: return 32'h0000_00B8;
        endcase
    endfunction

endpackage

// File: rtl/ssc_bounds.sv
// Computes the modulation window from the nominal divide word and depth code.
// Pure combinational logic; the caller captures the results.
// Assumes nominal * (1 + 31/1000) still fits in W bits.
module ssc_bounds #(
    parameter int W        = 36,
    parameter int SPREAD_W = 5
) (
    input  logic [W-1:0]        nom,
    input  logic [SPREAD_W-1:0] spread,
    input  ssc_pkg::place_e     place,
    output logic [W-1:0]        lo,
    output logic [W-1:0]        hi
);
    localparam int PW = W + SPREAD_W;
    localparam logic [PW-1:0] DENOM = PW'(ssc_pkg::PERMILLE);

    logic [PW-1:0] prod;
    logic [W-1:0]  dev;

    // Deviation in fraction LSBs, then the window for the chosen placement.
    always_comb begin
        prod = PW'(nom) * PW'(spread);
        dev  = W'(prod / DENOM);
        lo   = nom - dev;
        hi   = (place == ssc_pkg::PLACE_DOWN) ? nom : nom + dev;
    end

endmodule

// File: rtl/ssc_tick.sv
// Update-rate counter: asserts tick once every rate+1 clocks.
// A restart clears the count and suppresses the tick in that cycle.
module ssc_tick #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt;

    // Tick when the count has reached the live rate setting.
    always_comb tick = (cnt >= rate) && !restart;

    // Count clocks between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ssc_tri.sv
// Triangle sweep between lo and hi with a step derived from the span.
// Assumes lo <= hi and that load places the value inside the window.
module ssc_tri #(
    parameter int W          = 36,
    parameter int STEP_SHIFT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] cur
);
    logic [W-1:0] span;
    logic [W-1:0] raw;
    logic [W-1:0] step;
    logic         up;

    // Step size: span scaled down, never below one LSB.
    always_comb begin
        span = hi - lo;
        raw  = span >> STEP_SHIFT;
        step = (raw == '0) ? W'(1) : raw;
    end

    // Move one step per advance, clamping onto a bound and turning there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
            up  <= 1'b1;
        end else if (load) begin
            cur <= load_val;
            up  <= 1'b1;
        end else if (adv) begin
            if (up) begin
                if ((hi - cur) <= step) begin
                    cur <= hi;
                    up  <= 1'b0;
                end else begin
                    cur <= cur + step;
                end
            end else begin
                if ((cur - lo) <= step) begin
                    cur <= lo;
                    up  <= 1'b1;
                end else begin
                    cur <= cur - step;
                end
            end
        end
    end

endmodule

// File: rtl/ssc_prng.sv
// Pseudo-random walk: a maximal-length LFSR scaled into [lo, hi).
// The LFSR runs only on advances and is not reseeded by load.
module ssc_prng #(
    parameter int W      = 36,
    parameter int LFSR_W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] val
);
    localparam int MW = W + LFSR_W;
    localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(ssc_pkg::lfsr_taps(LFSR_W));

    logic [LFSR_W-1:0] lfsr;
    logic [LFSR_W-1:0] nxt;
    logic [MW-1:0]     prod;
    logic [W-1:0]      scaled;

    // Next LFSR state and its scaling onto the window span.
    always_comb begin
        nxt    = {lfsr[LFSR_W-2:0], ^(lfsr & TAPS)};
        prod   = MW'(hi - lo) * MW'(nxt);
        scaled = prod[MW-1:LFSR_W];
    end

    // Hold the LFSR state and the scaled output value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= LFSR_W'(1);
            val  <= '0;
        end else if (load) begin
            val  <= load_val;
        end else if (adv) begin
            lfsr <= nxt;
            val  <= lo + scaled;
        end
    end

endmodule

// File: rtl/ssc_divmod.sv
// Spread spectrum divider modulator top.
// Captures the nominal word, depth, placement and shape when the enable rises.
// Produces a modulated 12.24 divide word with a strobe on every update.
// When disabled, the nominal input passes straight to the output.
module ssc_divmod #(
    parameter int INT_W      = 12,
    parameter int FRAC_W     = 24,
    parameter int SPREAD_W   = 5,
    parameter int RATE_W     = 16,
    parameter int STEP_SHIFT = 4,
    parameter int LFSR_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [INT_W-1:0]    nom_int,
    input  logic [FRAC_W-1:0]   nom_frac,
    input  logic [SPREAD_W-1:0] spread,
    input  logic                down_mode,
    input  logic                shape_prng,
    input  logic [RATE_W-1:0]   rate,
    output logic [INT_W-1:0]    div_int,
    output logic [FRAC_W-1:0]   div_frac,
    output logic                div_valid
);
    import ssc_pkg::*;

    localparam int W = INT_W + FRAC_W;

    logic [W-1:0] nom_c;
    logic [W-1:0] lo_c, hi_c;
    logic [W-1:0] lo_q, hi_q;
    logic [W-1:0] tri_v, rnd_v, mod_v;
    logic         en_q, rise, tick, adv, valid_q;
    place_e       place_c;
    shape_e       shape_q;

    // Input decode and enable edge detect.
    always_comb begin
        nom_c   = {nom_int, nom_frac};
        place_c = down_mode ? PLACE_DOWN : PLACE_CENTER;
        rise    = en && !en_q;
        adv     = tick && en_q;
    end

    ssc_bounds #(.W(W), .SPREAD_W(SPREAD_W)) i_bounds (
        .nom    (nom_c),
        .spread (spread),
        .place  (place_c),
        .lo     (lo_c),
        .hi     (hi_c)
    );

    ssc_tick #(.RATE_W(RATE_W)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rise),
        .rate    (rate),
        .tick    (tick)
    );

    ssc_tri #(.W(W), .STEP_SHIFT(STEP_SHIFT)) i_tri (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rise),
        .load_val (lo_c),
        .adv      (adv),
        .lo       (lo_q),
        .hi       (hi_q),
        .cur      (tri_v)
    );

    ssc_prng #(.W(W), .LFSR_W(LFSR_W)) i_prng (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rise),
        .load_val (lo_c),
        .adv      (adv),
        .lo       (lo_q),
        .hi       (hi_q),
        .val      (rnd_v)
    );

    // Enable tracking, update strobe, and settings capture on enable rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            valid_q <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            shape_q <= SHAPE_TRI;
        end else begin
            en_q    <= en;
            valid_q <= tick;
            if (rise) begin
                lo_q    <= lo_c;
                hi_q    <= hi_c;
                shape_q <= shape_prng ? SHAPE_PRNG : SHAPE_TRI;
            end
        end
    end

    // Output select: modulated value when active, nominal otherwise.
    always_comb begin
        mod_v     = (shape_q == SHAPE_PRNG) ? rnd_v : tri_v;
        {div_int, div_frac} = en_q ? mod_v : nom_c;
        div_valid = valid_q;
    end

endmodule

// File: rtl/ssc_divmod_chk.sv
// Property checker for ssc_divmod, attached by bind below.
// Keeps its own copy of the captured nominal and depth for reference.
module ssc_divmod_chk #(
    parameter int INT_W    = 12,
    parameter int FRAC_W   = 24,
    parameter int SPREAD_W = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en,
    input logic                       en_q,
    input logic [INT_W-1:0]           nom_int,
    input logic [FRAC_W-1:0]          nom_frac,
    input logic [SPREAD_W-1:0]        spread,
    input logic                       down_mode,
    input logic [INT_W-1:0]           div_int,
    input logic [FRAC_W-1:0]          div_frac,
    input logic                       div_valid,
    input logic [INT_W+FRAC_W-1:0]    lo_q,
    input logic [INT_W+FRAC_W-1:0]    hi_q
);
    localparam int W = INT_W + FRAC_W;

    logic [W-1:0]        out_v;
    logic [W-1:0]        nom_ck;
    logic [SPREAD_W-1:0] spr_ck;
    logic                dn_ck;

    // Assemble the output word.
    always_comb out_v = {div_int, div_frac};

    // Independent capture of the settings seen on enable rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nom_ck <= '0;
            spr_ck <= '0;
            dn_ck  <= 1'b0;
        end else if (en && !en_q) begin
            nom_ck <= {nom_int, nom_frac};
            spr_ck <= spread;
            dn_ck  <= down_mode;
        end
    end

    p_window_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> lo_q <= hi_q);

    p_down_below_nominal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && dn_ck) |-> out_v <= nom_ck);

    p_zero_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && spr_ck == '0) |-> out_v == nom_ck);

    p_start_at_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> out_v == lo_q);

    p_inside_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> (out_v >= lo_q && out_v <= hi_q));

    p_hold_between_updates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !div_valid) |-> $stable(out_v));

endmodule

bind ssc_divmod ssc_divmod_chk #(
    .INT_W    (INT_W),
    .FRAC_W   (FRAC_W),
    .SPREAD_W (SPREAD_W)
) i_ssc_divmod_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .en_q      (en_q),
    .nom_int   (nom_int),
    .nom_frac  (nom_frac),
    .spread    (spread),
    .down_mode (down_mode),
    .div_int   (div_int),
    .div_frac  (div_frac),
    .div_valid (div_valid),
    .lo_q      (lo_q),
    .hi_q      (hi_q)
);

// File: tb/test_ssc_divmod.sv
`timescale 1ns/1ps
module test_ssc_divmod;
    localparam int INT_W      = 12;
    localparam int FRAC_W     = 24;
    localparam int SPREAD_W   = 5;
    localparam int RATE_W     = 8;
    localparam int STEP_SHIFT = 3;
    localparam int LFSR_W     = 8;
    localparam int W          = INT_W + FRAC_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                en = 1'b0;
    logic [INT_W-1:0]    nom_int = '0;
    logic [FRAC_W-1:0]   nom_frac = '0;
    logic [SPREAD_W-1:0] spread = '0;
    logic                down_mode = 1'b0;
    logic                shape_prng = 1'b0;
    logic [RATE_W-1:0]   rate = '0;
    logic [INT_W-1:0]    div_int;
    logic [FRAC_W-1:0]   div_frac;
    logic                div_valid;
    logic [W-1:0]        outv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign outv = {div_int, div_frac};

    ssc_divmod #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .SPREAD_W(SPREAD_W),
        .RATE_W(RATE_W), .STEP_SHIFT(STEP_SHIFT), .LFSR_W(LFSR_W)
    ) i_ssc_divmod (
        .clk(clk), .rst_n(rst_n), .en(en), .nom_int(nom_int), .nom_frac(nom_frac),
        .spread(spread), .down_mode(down_mode), .shape_prng(shape_prng), .rate(rate),
        .div_int(div_int), .div_frac(div_frac), .div_valid(div_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] f_dev(input logic [W-1:0] n, input logic [SPREAD_W-1:0] s);
        logic [63:0] p;
        p = 64'(n) * 64'(s);
        return W'(p / 64'd1000);
    endfunction

    function automatic logic [W-1:0] f_lo(input logic [W-1:0] n, input logic [SPREAD_W-1:0] s);
        return n - f_dev(n, s);
    endfunction

    function automatic logic [W-1:0] f_hi(input logic [W-1:0] n, input logic [SPREAD_W-1:0] s, input bit d);
        return d ? n : n + f_dev(n, s);
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input logic [W-1:0] n, input logic [SPREAD_W-1:0] s, input bit d,
                       input bit p, input logic [RATE_W-1:0] r, input bit scr,
                       output logic [W-1:0] mn, output logic [W-1:0] mx);
        logic [W-1:0] lo, hi, cur, step, lastv;
        bit up;
        int gap, changes, ncyc;
        {nom_int, nom_frac} = n;
        spread = s; down_mode = d; shape_prng = p; rate = r; en = 1'b0;
        cyc();
        cyc();
        chk(outv == n, "R1 disabled output follows nominal", 64'(outv), 64'(n));
        en = 1'b1;
        cyc();
        lo = f_lo(n, s);
        hi = f_hi(n, s, d);
        chk(outv == lo, "R5 capture edge loads lower bound", 64'(outv), 64'(lo));
        if (scr) begin
            nom_int = INT_W'($urandom);
            nom_frac = FRAC_W'($urandom);
            spread = SPREAD_W'($urandom);
            down_mode = 1'($urandom);
            shape_prng = 1'($urandom);
        end
        step = (hi - lo) >> STEP_SHIFT;
        if (step == '0) step = 1;
        cur = lo; up = 1'b1; gap = 0; changes = 0;
        lastv = outv; mn = outv; mx = outv;
        ncyc = (int'(r) + 1) * 40;
        for (int i = 0; i < ncyc; i++) begin
            cyc();
            gap++;
            if (div_valid) begin
                chk(gap == int'(r) + 1, "R7 update interval", 64'(gap), 64'(int'(r) + 1));
                gap = 0;
                if (!p) begin
                    if (up) begin
                        if (hi - cur <= step) begin cur = hi; up = 1'b0; end
                        else cur = cur + step;
                    end else begin
                        if (cur - lo <= step) begin cur = lo; up = 1'b1; end
                        else cur = cur - step;
                    end
                    chk(outv == cur, scr ? "R8 triangle unaffected by setting changes" : "R5 triangle step",
                        64'(outv), 64'(cur));
                end else begin
                    chk(outv >= lo && (outv < hi || lo == hi),
                        scr ? "R8 random window unaffected by setting changes" : "R6 random value in window",
                        64'(outv), 64'(lo));
                    if (outv != lastv) changes++;
                end
            end else begin
                chk(outv == lastv, "R7 output holds between updates", 64'(outv), 64'(lastv));
            end
            lastv = outv;
            if (outv < mn) mn = outv;
            if (outv > mx) mx = outv;
        end
        if (!p) begin
            chk(mn == lo, d ? "R3 down placement lower bound" : "R2 centre lower bound", 64'(mn), 64'(lo));
            chk(mx == hi, d ? "R3 down placement upper bound is nominal" : "R2 centre upper bound",
                64'(mx), 64'(hi));
        end else if ((hi - lo) >= W'(1 << LFSR_W)) begin
            chk(changes > 0, "R6 random sequence varies", 64'(changes), 64'd1);
        end
        if (s == '0) chk(mn == n && mx == n, "R4 zero depth holds nominal", 64'(mx), 64'(n));
        en = 1'b0;
        cyc();
        chk(outv == {nom_int, nom_frac}, "R9 nominal after disable", 64'(outv), 64'({nom_int, nom_frac}));
    endtask

    initial begin : main
        logic [W-1:0] mn, mx;
        logic [W-1:0] n;
        void'($urandom(32'd20240611));
        nom_int = 12'd50;
        nom_frac = '0;
        cyc();
        cyc();
        chk(outv == 36'h032_000000, "R1 nominal during reset", 64'(outv), 64'h032000000);
        chk(div_valid == 1'b0, "R1 no strobe during reset", 64'(div_valid), 64'd0);
        rst_n = 1'b1;
        cyc();

        run(36'h032_000000, 5'd15, 1'b0, 1'b0, 8'd1, 1'b0, mn, mx);
        chk(mn == 36'h031_400000, "R2 example minimum 49.25", 64'(mn), 64'h031400000);
        chk(mx == 36'h032_C00000, "R2 example maximum 50.75", 64'(mx), 64'h032C00000);
        run(36'h032_000000, 5'd15, 1'b1, 1'b0, 8'd2, 1'b0, mn, mx);
        chk(mn == 36'h031_400000, "R3 down example minimum", 64'(mn), 64'h031400000);
        chk(mx == 36'h032_000000, "R3 down example maximum", 64'(mx), 64'h032000000);
        run(36'h032_000000, 5'd0, 1'b0, 1'b0, 8'd0, 1'b0, mn, mx);
        run(36'h032_000000, 5'd0, 1'b0, 1'b1, 8'd1, 1'b0, mn, mx);
        run(36'hEFF_FFFFFF, 5'd31, 1'b0, 1'b0, 8'd3, 1'b0, mn, mx);
        run(36'hEFF_FFFFFF, 5'd31, 1'b0, 1'b1, 8'd0, 1'b0, mn, mx);
        run(36'h001_000000, 5'd1, 1'b0, 1'b0, 8'd0, 1'b0, mn, mx);
        run(36'h032_000000, 5'd20, 1'b0, 1'b0, 8'd1, 1'b1, mn, mx);

        for (int k = 0; k < 40; k++) begin
            n = {INT_W'($urandom_range(1, 3900)), FRAC_W'($urandom)};
            run(n, SPREAD_W'($urandom), 1'($urandom), 1'($urandom),
                RATE_W'($urandom_range(0, 3)), 1'($urandom), mn, mx);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule